// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Transfer Strobe

This block presents a five-digit BCD conversion result on a time-multiplexed interface. One output carries a one-hot digit-select for a display. A second output is a 4-bit BCD bus that always holds the digit currently selected. A third output is an active-low strobe that external latches or a host can use to capture each digit. The result is captured into a hold register when the sequencer signals that a conversion has ended. The scanner then runs one pass from the most significant digit down to the least significant digit, with one strobe pulse centred in each digit window. After that pass it keeps refreshing the display without strobes.

When the finished conversion was over range, the display goes dark after the strobed pass. It stays dark until the sequencer reports the start of the next deintegrate phase. Scanning then resumes without strobes. A fresh conversion-end event always restarts the strobed pass at the most significant digit.

The controller has four states. `ST_IDLE` holds from reset until the first conversion end. `ST_STROBED` is the strobed pass. `ST_FREE` is strobe-free refresh. `ST_BLANK` is the dark display after an over-range result. The transitions are:

- any state goes to `ST_STROBED` on `conv_done`;
- `ST_STROBED` goes to `ST_FREE` at the end of the least significant window when the latched over-range flag is clear;
- `ST_STROBED` goes to `ST_BLANK` at the same point when the flag is set;
- `ST_BLANK` goes to `ST_FREE` on `deint_start`;
- `ST_FREE` wraps from the least significant digit back to the most significant digit and stays in `ST_FREE`.

Top module: `bcd_digit_scanner`

## Requirements
- R1: After reset, `dig_drive` is 0, `bcd` is 0 and `strobe_n` is high. These values hold until the first `conv_done`.
- R2: At most one bit of `dig_drive` is high at a time. Bit 4 selects the most significant digit and bit 0 the least significant. Scanning proceeds from bit 4 down to bit 0.
- R3: `bcd` equals the held digit of the active drive line, where digit k is `digits[4k+3:4k]`. `bcd` is 0 whenever no drive line is active.
- R4: `digits` and `over_flag` are sampled only on a clock edge where `conv_done` is high. Changes to them at other times do not alter the outputs.
- R5: The first window after `conv_done` is the most significant digit window, and it lasts 201 cycles. Every other window lasts 200 cycles. The first window begins in the cycle after the edge that sampled `conv_done`.
- R6: During the strobed pass only, `strobe_n` is low for the second half of the cycle at index 101 of each window, counting the window's first cycle as index 0. This gives five pulses per conversion.
- R7: After the strobed pass with no over-range, the scanner repeats bit 4 down to bit 0 windows of 200 cycles, and `strobe_n` stays high.
- R8: After a strobed pass of an over-range conversion, `dig_drive` and `bcd` are 0 until an edge that samples `deint_start`. From the next cycle, strobe-free scanning restarts at bit 4.
- R9: `deint_start` has no effect unless the display is blanked by R8.
- R10: `conv_done` during any scan restarts the strobed pass at bit 4 in the next cycle, with the newly sampled digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe also uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits | input | 20 | Result digits, digit k at bits 4k+3:4k, k=4 most significant |
| conv_done | input | 1 | One-cycle conversion-end event |
| over_flag | input | 1 | Over-range indication, sampled with conv_done |
| deint_start | input | 1 | One-cycle start-of-deintegrate event |
| dig_drive | output | 5 | One-hot digit select, bit 4 = most significant |
| bcd | output | 4 | BCD value of the selected digit |
| strobe_n | output | 1 | Active-low half-cycle transfer strobe |

## Verification
`dig_drive` and `bcd` change one cycle after the rising edge that samples `conv_done`, `deint_start` or a window end. They are therefore read a quarter period after every rising edge. The bench predicts each cycle's values at the moment it drives that cycle's inputs and queues the prediction. It then compares the prediction after the next rising edge. The strobe is due in the second half of the window's cycle at index 101. The monitor reads `strobe_n` both a quarter period and three quarters of a period after each edge, so a strobe that is too long, too short or misplaced by one cycle is caught.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBED,
        ST_FREE,
        ST_BLANK
    } scan_state_e;
endpackage

// File: rtl/bcd_hold_latch.sv
module bcd_hold_latch #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4,
    localparam int SEL_W     = $clog2(NUM_DIGITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] din,
    input  logic [SEL_W-1:0]              sel,
    output logic [DIGIT_W-1:0]            digit
);
    logic [DIGIT_W-1:0] held_q [NUM_DIGITS];

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                held_q[k] <= '0;
            else if (load)
                held_q[k] <= din[k*DIGIT_W +: DIGIT_W];
        end
    end

    always_comb begin
        digit = '0;
        for (int k = 0; k < NUM_DIGITS; k++)
            if (sel == SEL_W'(k))
                digit = held_q[k];
    end
endmodule

// File: rtl/scan_window_timer.sv
module scan_window_timer #(
    parameter int DWELL = 200,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             long_win,
    output logic [CNT_W-1:0] cnt,
    output logic             win_end
);
    logic [CNT_W-1:0] last;

    always_comb begin
        last    = long_win ? CNT_W'(DWELL) : CNT_W'(DWELL - 1);
        win_end = run && !restart && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run || win_end)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/strobe_pulse_gen.sv
module strobe_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic strobe_n
);
    logic half_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            half_q <= 1'b0;
        else
            half_q <= en;
    end

    assign strobe_n = ~(en & half_q);
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4,
    parameter int DWELL      = 200,
    parameter int STROBE_AT  = 101
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits,
    input  logic                          conv_done,
    input  logic                          over_flag,
    input  logic                          deint_start,
    output logic [NUM_DIGITS-1:0]         dig_drive,
    output logic [DIGIT_W-1:0]            bcd,
    output logic                          strobe_n
);
    import scan_pkg::*;

    localparam int SEL_W = $clog2(NUM_DIGITS);
    localparam int CNT_W = $clog2(DWELL + 2);
    localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NUM_DIGITS - 1);

    scan_state_e      state_q, state_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             ovr_q;
    logic             restart, run, long_win, win_end, strobe_en;
    logic [CNT_W-1:0] cnt;
    logic [DIGIT_W-1:0] cur_digit;

    bcd_hold_latch #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(conv_done), .din(digits),
        .sel(sel_q), .digit(cur_digit)
    );

    scan_window_timer #(.DWELL(DWELL), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
        .long_win(long_win), .cnt(cnt), .win_end(win_end)
    );

    strobe_pulse_gen u_strobe (
        .clk(clk), .rst_n(rst_n), .en(strobe_en), .strobe_n(strobe_n)
    );

    always_comb begin
        run      = (state_q == ST_STROBED) || (state_q == ST_FREE);
        long_win = (state_q == ST_STROBED) && (sel_q == TOP_SEL);
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        restart = 1'b0;
        if (conv_done) begin
            state_d = ST_STROBED;
            sel_d   = TOP_SEL;
            restart = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_STROBED, ST_FREE: begin
                    if (win_end) begin
                        if (sel_q == '0) begin
                            sel_d = TOP_SEL;
                            if (state_q == ST_STROBED)
                                state_d = ovr_q ? ST_BLANK : ST_FREE;
                        end else begin
                            sel_d = sel_q - SEL_W'(1);
                        end
                    end
                end
                ST_BLANK: begin
                    if (deint_start) begin
                        state_d = ST_FREE;
                        sel_d   = TOP_SEL;
                        restart = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= TOP_SEL;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            if (conv_done)
                ovr_q <= over_flag;
        end
    end

    always_comb begin
        dig_drive = run ? (NUM_DIGITS'(1) << sel_q) : '0;
        bcd       = run ? cur_digit : '0;
        strobe_en = (state_q == ST_STROBED) && (cnt == CNT_W'(STROBE_AT));
    end
endmodule

// File: rtl/bcd_digit_scanner_checker.sv
module bcd_digit_scanner_checker #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  conv_done,
    input logic                  deint_start,
    input logic [NUM_DIGITS-1:0] dig_drive,
    input logic [DIGIT_W-1:0]    bcd,
    input logic                  strobe_n
);
    assert_onehot_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_drive));

    assert_dark_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_drive == '0) |-> (bcd == '0));

    assert_held_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done ##1 $stable(dig_drive) |-> $stable(bcd));

    assert_strobe_in_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> (dig_drive != '0));

    assert_dark_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_drive == '0) && !conv_done && !deint_start |=> (dig_drive == '0));

    assert_restart_msd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> dig_drive[NUM_DIGITS-1]);
endmodule

bind bcd_digit_scanner bcd_digit_scanner_checker #(
    .NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .deint_start(deint_start),
    .dig_drive(dig_drive), .bcd(bcd), .strobe_n(strobe_n)
);

// File: tb/bcd_digit_scanner_bench.sv
`timescale 1ns/1ps
module bcd_digit_scanner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] digits = '0;
    logic        conv_done = 1'b0, over_flag = 1'b0, deint_start = 1'b0;
    logic [4:0]  dig_drive;
    logic [3:0]  bcd;
    logic        strobe_n;

    always #10 clk = ~clk;

    bcd_digit_scanner u_bcd_digit_scanner (
        .clk(clk), .rst_n(rst_n), .digits(digits), .conv_done(conv_done),
        .over_flag(over_flag), .deint_start(deint_start),
        .dig_drive(dig_drive), .bcd(bcd), .strobe_n(strobe_n)
    );

    typedef struct {
        logic [4:0] drv;
        logic [3:0] val;
        bit         low;
        string      req;
    } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0;
    bit done = 0;
    string extra_tag = "";

    // reference expectation: 0 idle, 1 strobed, 2 free, 3 blank
    int m_st = 0, m_sel = 4, m_cnt = 0;
    bit m_ovr = 0;
    logic [19:0] m_dig = '0;

    task automatic step(input bit c, input bit o, input bit d, input logic [19:0] din);
        exp_t e;
        int len;
        @(negedge clk);
        conv_done = c; over_flag = o; deint_start = d; digits = din;
        if (c) begin
            m_dig = din; m_ovr = o; m_st = 1; m_sel = 4; m_cnt = 0;
        end else if (m_st == 1 || m_st == 2) begin
            len = (m_st == 1 && m_sel == 4) ? 201 : 200;
            if (m_cnt == len - 1) begin
                m_cnt = 0;
                if (m_sel == 0) begin
                    m_sel = 4;
                    if (m_st == 1) m_st = m_ovr ? 3 : 2;
                end else m_sel = m_sel - 1;
            end else m_cnt = m_cnt + 1;
        end else if (m_st == 3 && d) begin
            m_st = 2; m_sel = 4; m_cnt = 0;
        end
        if (m_st == 1 || m_st == 2) begin
            e.drv = 5'(1) << m_sel;
            e.val = m_dig[m_sel*4 +: 4];
        end else begin
            e.drv = '0; e.val = '0;
        end
        e.low = (m_st == 1) && (m_cnt == 101);
        case (m_st)
            0: e.req = "R1";
            1: e.req = "R2 R3 R5 R6";
            2: e.req = "R2 R3 R7";
            default: e.req = "R8";
        endcase
        e.req = {e.req, extra_tag};
        q.push_back(e);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, digits);
    endtask

    // monitor: compare a quarter and three quarters of a period after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (dig_drive !== e.drv || bcd !== e.val || strobe_n !== 1'b1) begin
                    fails++;
                    $display("FAIL %s @%0t: drive=%b bcd=%0d strobe_n=%b expected drive=%b bcd=%0d strobe_n=1",
                             e.req, $time, dig_drive, bcd, strobe_n, e.drv, e.val);
                end
                #10;
                checks++;
                if (strobe_n !== !e.low) begin
                    fails++;
                    $display("FAIL %s @%0t late half: strobe_n=%b expected %b",
                             e.req, $time, strobe_n, !e.low);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (dig_drive !== 5'b0 || bcd !== 4'b0 || strobe_n !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: drive=%b bcd=%0d strobe_n=%b expected 0/0/1", dig_drive, bcd, strobe_n);
        end
        @(negedge clk) rst_n = 1'b1;
        // R1 R9: idle with a deintegrate event and changing digits
        extra_tag = " R9";
        run(5);
        step(0, 0, 1, 20'h12345);
        run(5);
        // normal conversion: digits 1,9,8,7,6 (MSD first)
        extra_tag = "";
        step(1, 0, 0, 20'h19876);
        run(1000);
        // R4: input changes after capture are not shown
        extra_tag = " R4";
        step(0, 1, 0, 20'h05555);
        run(500);
        // R9: deintegrate event during free scan ignored
        extra_tag = " R9";
        step(0, 0, 1, 20'h05555);
        run(600);
        // over-range conversion
        extra_tag = "";
        step(1, 1, 0, 20'h13579);
        run(400);
        extra_tag = " R9";
        step(0, 0, 1, 20'h13579);
        extra_tag = "";
        run(900);
        extra_tag = " R8";
        step(0, 0, 1, 20'h00000);
        run(450);
        // R10: conversion end in mid scan restarts the strobed pass
        extra_tag = " R10";
        step(1, 0, 0, 20'h02468);
        run(1500);
        extra_tag = "";
        run(3);
        @(posedge clk); @(posedge clk);
        #18;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule